// File: doc/BRIEF.md
# Triggered Waveform Playback Sequencer

This block replays waveforms held in a shared sample memory to sixteen DAC channels. The memory is split into a lower and an upper half. Each half holds one segment per channel, so a channel's samples run from the start of its lower segment to the end of its upper segment. Once the block is enabled, armed and triggered, every update strobe starts one frame. In a frame the block reads one sample per channel, in channel order, at the current sample position. It hands each sample, tagged with its channel number, to the downstream DAC loader. After the frame the position advances by one.

A trigger plays a programmed number of updates. A count of zero means the full per-channel depth. The position is kept from one trigger to the next and wraps to zero past the last sample. In repeat mode the position returns to zero at the end of each count and playback starts again with no completion event. Sticky status flags record the following events:
- the lower half was read to its top,
- the upper half was read to its top,
- a count finished,
- an inhibit occurred.

The first three flags can each raise the interrupt line through their own enable bit.

Both streaming interfaces use valid/ready. A request or a sample that is offered stays offered, with stable content, until ready is seen high at a clock edge. The memory returns one response per request, in order. The block keeps only one read in flight, and while a sample waits on back-pressure it issues no further read.

Top module: `wfp_playback_seq`

## Requirements
- R1: A trigger (`sw_trig` or `ext_trig` high for a cycle) starts playback only when `cfg_ex` and `cfg_arm` are both 1 and no playback is running. Otherwise the trigger is ignored, and later strobes produce no reads and no samples.
- R2: Each accepted `upd_strobe` during playback produces exactly 16 samples, on channels 0 to 15 in rising order. Each sample carries the memory word read at address {half, channel[3:0], index}.
- R3: A trigger loads the remaining count from `upd_count`. Each completed frame decrements it. When the last frame finishes, playback stops and flag bit 0 (done) is set. Later strobes produce nothing.
- R4: An `upd_count` of 0 plays the whole per-channel depth: 2·2^IDX_W frames, or 2^IDX_W frames in reduced mode.
- R5: The sample position persists across triggers. It advances by one per frame and wraps to 0 after the last position of the selected depth.
- R6: A frame that reads the top position of the lower half sets flag bit 2 (half). A frame that reads the top position of the upper half sets flag bit 1 (full).
- R7: `irq` is high exactly while some flag among bits 0, 1 and 2 is set and its enable is set. The enables are `cfg_irq_en` bit 0 for done, bit 1 for full and bit 2 for half.
- R8: With `cfg_cont` and `cfg_arm` both 1 at the end of a count, the position returns to 0, the count reloads, playback continues and done is not set.
- R9: With `cfg_small` = 1 each half holds 2^(IDX_W-1) samples per channel. The position then maps to half = pos[IDX_W-1] and index = {0, pos[IDX_W-2:0]}. With `cfg_small` = 0 the mapping is half = pos[IDX_W] and index = pos[IDX_W-1:0].
- R10: While `cfg_inh_en` and `inhibit_in` are both 1, strobes are ignored and flag bit 3 (inhibit) is set.
- R11: Flags are sticky. Writing 1 to a bit of `flag_clr` clears that flag, unless it is set again in the same cycle.
- R12: A strobe that arrives while a frame is still in progress is ignored.
- R13: Under back-pressure an offered request or sample keeps valid high and its content stable until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ex | input | 1 | Memory playback enable |
| cfg_arm | input | 1 | Arm |
| cfg_cont | input | 1 | Repeat at end of count |
| cfg_small | input | 1 | Reduced per-channel depth |
| cfg_inh_en | input | 1 | Let `inhibit_in` stop updates |
| cfg_irq_en | input | 3 | Interrupt enables: done, full, half |
| upd_count | input | CNT_W | Updates per trigger, 0 = whole memory |
| sw_trig | input | 1 | Software trigger pulse |
| ext_trig | input | 1 | External trigger pulse |
| inhibit_in | input | 1 | External inhibit level |
| upd_strobe | input | 1 | Update clock pulse |
| flag_clr | input | 4 | Write-1-to-clear for the flags |
| flags | output | 4 | {inhibit, half, full, done} |
| irq | output | 1 | Interrupt request |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request ready |
| mem_req_addr | output | ADDR_W | Read address {half, channel, index} |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Read data ready |
| mem_rsp_data | input | DATA_W | Read data |
| smp_valid | output | 1 | Sample valid |
| smp_ready | input | 1 | Sample ready |
| smp_ch | output | CH_W | Sample channel |
| smp_data | output | DATA_W | Sample value |

## Verification
Playback is exercised with several count patterns:
- short counts, where the position stays inside the lower half;
- counts that cross the lower-half top and the wrap point;
- a zero count, which plays the whole depth;
- repeated counts in repeat mode, which reveal whether the position resets to zero instead of wrapping.

Each of these runs in both depth modes, so the two address mappings and the two pairs of flag positions are told apart. Every memory word encodes its own address, so the scoreboard detects any wrong channel order or wrong position. Irregular ready patterns on both streams show whether back-pressure loses or duplicates samples. Strobes sent while disabled, inhibited, or in the middle of a frame must leave no sample behind.

// File: rtl/wfp_pkg.sv
package wfp_pkg;
  typedef enum logic [1:0] {
    FS_IDLE,
    FS_REQ,
    FS_RSP,
    FS_OUT
  } frame_st_e;

  localparam int FLG_DONE = 0;
  localparam int FLG_FULL = 1;
  localparam int FLG_HALF = 2;
  localparam int FLG_INH  = 3;
  localparam int NFLG     = 4;
  localparam int NIRQ     = 3;
endpackage

// File: rtl/wfp_run_ctl.sv
module wfp_run_ctl #(
  parameter int IDX_W = 15,
  parameter int CNT_W = 16,
  localparam int PTR_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_ex,
  input  logic             cfg_arm,
  input  logic             cfg_cont,
  input  logic             cfg_small,
  input  logic             trig,
  input  logic [CNT_W-1:0] upd_count,
  input  logic             frame_done,
  output logic             run_active,
  output logic [PTR_W-1:0] pos,
  output logic             set_done,
  output logic             set_full,
  output logic             set_half
);
  localparam int REM_W = ((CNT_W > PTR_W) ? CNT_W : PTR_W) + 1;

  logic             run_q;
  logic [PTR_W-1:0] pos_q, last_pos, half_pos, pos_nxt;
  logic [REM_W-1:0] rem_q, reload;
  logic             step, last_frame, again;

  always_comb begin
    last_pos   = cfg_small ? {1'b0, {IDX_W{1'b1}}} : {PTR_W{1'b1}};
    half_pos   = last_pos >> 1;
    pos_nxt    = (pos_q == last_pos) ? '0 : pos_q + 1'b1;
    reload     = (upd_count == '0) ? (REM_W'(last_pos) + REM_W'(1))
                                   : REM_W'(upd_count);
    step       = run_q & frame_done;
    last_frame = (rem_q == REM_W'(1));
    again      = cfg_cont & cfg_arm;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      pos_q <= '0;
      rem_q <= '0;
    end else if (trig && cfg_ex && cfg_arm && !run_q) begin
      run_q <= 1'b1;
      rem_q <= reload;
    end else if (step) begin
      if (last_frame && again) begin
        rem_q <= reload;
        pos_q <= '0;
      end else begin
        if (last_frame) run_q <= 1'b0;
        rem_q <= rem_q - 1'b1;
        pos_q <= pos_nxt;
      end
    end
  end

  assign run_active = run_q;
  assign pos        = pos_q;
  assign set_done   = step & last_frame & ~again;
  assign set_full   = step & (pos_q == last_pos);
  assign set_half   = step & (pos_q == half_pos);
endmodule

// File: rtl/wfp_frame_seq.sv
module wfp_frame_seq
  import wfp_pkg::*;
#(
  parameter int IDX_W  = 15,
  parameter int NCH    = 16,
  parameter int DATA_W = 16,
  localparam int CH_W   = $clog2(NCH),
  localparam int PTR_W  = IDX_W + 1,
  localparam int ADDR_W = 1 + CH_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              cfg_small,
  input  logic [PTR_W-1:0]  pos,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              smp_valid,
  input  logic              smp_ready,
  output logic [CH_W-1:0]   smp_ch,
  output logic [DATA_W-1:0] smp_data,
  output logic              busy,
  output logic              frame_done
);
  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NCH - 1);

  frame_st_e          st_q;
  logic [CH_W-1:0]    ch_q;
  logic [DATA_W-1:0]  data_q;
  logic               half_b;
  logic [IDX_W-1:0]   idx;

  always_comb begin
    half_b = cfg_small ? pos[IDX_W-1] : pos[IDX_W];
    idx    = cfg_small ? {1'b0, pos[IDX_W-2:0]} : pos[IDX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= FS_IDLE;
      ch_q   <= '0;
      data_q <= '0;
    end else begin
      unique case (st_q)
        FS_IDLE: if (go) begin
          st_q <= FS_REQ;
          ch_q <= '0;
        end
        FS_REQ: if (mem_req_ready) st_q <= FS_RSP;
        FS_RSP: if (mem_rsp_valid) begin
          data_q <= mem_rsp_data;
          st_q   <= FS_OUT;
        end
        FS_OUT: if (smp_ready) begin
          if (ch_q == LAST_CH) st_q <= FS_IDLE;
          else begin
            ch_q <= ch_q + 1'b1;
            st_q <= FS_REQ;
          end
        end
        default: st_q <= FS_IDLE;
      endcase
    end
  end

  assign mem_req_valid = (st_q == FS_REQ);
  assign mem_req_addr  = {half_b, ch_q, idx};
  assign mem_rsp_ready = (st_q == FS_RSP);
  assign smp_valid     = (st_q == FS_OUT);
  assign smp_ch        = ch_q;
  assign smp_data      = data_q;
  assign busy          = (st_q != FS_IDLE);
  assign frame_done    = (st_q == FS_OUT) && smp_ready && (ch_q == LAST_CH);
endmodule

// File: rtl/wfp_flag_bank.sv
module wfp_flag_bank #(
  parameter int NF = 4,
  parameter int NI = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set_vec,
  input  logic [NF-1:0] clr_vec,
  input  logic [NI-1:0] irq_en,
  output logic [NF-1:0] flags,
  output logic          irq
);
  for (genvar g = 0; g < NF; g++) begin : g_flag
    logic f_q;
    always_ff @(posedge clk) begin
      if (!rst_n)          f_q <= 1'b0;
      else if (set_vec[g]) f_q <= 1'b1;
      else if (clr_vec[g]) f_q <= 1'b0;
    end
    assign flags[g] = f_q;
  end

  assign irq = |(flags[NI-1:0] & irq_en);
endmodule

// File: rtl/wfp_playback_seq.sv
module wfp_playback_seq
  import wfp_pkg::*;
#(
  parameter int IDX_W  = 15,
  parameter int NCH    = 16,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16,
  localparam int CH_W   = $clog2(NCH),
  localparam int ADDR_W = 1 + CH_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_ex,
  input  logic              cfg_arm,
  input  logic              cfg_cont,
  input  logic              cfg_small,
  input  logic              cfg_inh_en,
  input  logic [NIRQ-1:0]   cfg_irq_en,
  input  logic [CNT_W-1:0]  upd_count,
  input  logic              sw_trig,
  input  logic              ext_trig,
  input  logic              inhibit_in,
  input  logic              upd_strobe,
  input  logic [NFLG-1:0]   flag_clr,
  output logic [NFLG-1:0]   flags,
  output logic              irq,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              smp_valid,
  input  logic              smp_ready,
  output logic [CH_W-1:0]   smp_ch,
  output logic [DATA_W-1:0] smp_data
);
  localparam int PTR_W = IDX_W + 1;

  logic             run_active, busy, frame_done, go, inh_now;
  logic             set_done, set_full, set_half;
  logic [PTR_W-1:0] pos;
  logic [NFLG-1:0]  set_vec;

  assign inh_now = cfg_inh_en & inhibit_in;
  assign go      = run_active & upd_strobe & ~inh_now & ~busy;

  always_comb begin
    set_vec           = '0;
    set_vec[FLG_DONE] = set_done;
    set_vec[FLG_FULL] = set_full;
    set_vec[FLG_HALF] = set_half;
    set_vec[FLG_INH]  = inh_now;
  end

  wfp_run_ctl #(.IDX_W(IDX_W), .CNT_W(CNT_W)) run_i (
    .clk(clk), .rst_n(rst_n), .cfg_ex(cfg_ex), .cfg_arm(cfg_arm),
    .cfg_cont(cfg_cont), .cfg_small(cfg_small), .trig(sw_trig | ext_trig),
    .upd_count(upd_count), .frame_done(frame_done), .run_active(run_active),
    .pos(pos), .set_done(set_done), .set_full(set_full), .set_half(set_half)
  );

  wfp_frame_seq #(.IDX_W(IDX_W), .NCH(NCH), .DATA_W(DATA_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .go(go), .cfg_small(cfg_small), .pos(pos),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_ch(smp_ch),
    .smp_data(smp_data), .busy(busy), .frame_done(frame_done)
  );

  wfp_flag_bank #(.NF(NFLG), .NI(NIRQ)) flg_i (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(flag_clr),
    .irq_en(cfg_irq_en), .flags(flags), .irq(irq)
  );
endmodule

// File: rtl/wfp_playback_seq_chk.sv
module wfp_playback_seq_chk #(
  parameter int ADDR_W = 20,
  parameter int CH_W   = 4,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_ex,
  input logic              cfg_arm,
  input logic              cfg_inh_en,
  input logic              inhibit_in,
  input logic              run_active,
  input logic [3:0]        flags,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              smp_valid,
  input logic              smp_ready,
  input logic [CH_W-1:0]   smp_ch,
  input logic [DATA_W-1:0] smp_data
);
  AST_TRIG_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_active) |-> $past(cfg_ex && cfg_arm)); // R1

  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req_valid && smp_valid)); // R2

  AST_DONE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[0]) |-> !run_active); // R3

  AST_INH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_inh_en && inhibit_in) |=> flags[3]); // R10

  AST_SMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !smp_ready) |=> (smp_valid && $stable(smp_data) && $stable(smp_ch))); // R13

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R13
endmodule

bind wfp_playback_seq wfp_playback_seq_chk #(
  .ADDR_W(ADDR_W), .CH_W(CH_W), .DATA_W(DATA_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_ex(cfg_ex), .cfg_arm(cfg_arm),
  .cfg_inh_en(cfg_inh_en), .inhibit_in(inhibit_in), .run_active(run_active),
  .flags(flags), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .smp_valid(smp_valid), .smp_ready(smp_ready),
  .smp_ch(smp_ch), .smp_data(smp_data)
);

// File: tb/wfp_playback_seq_tb.sv
module wfp_playback_seq_tb_top;
  localparam int IDX_W = 3;
  localparam int AW    = 1 + 4 + IDX_W;

  logic clk = 0, rst_n = 0;
  logic cfg_ex = 0, cfg_arm = 0, cfg_cont = 0, cfg_small = 0, cfg_inh_en = 0;
  logic [2:0]  cfg_irq_en = 0;
  logic [15:0] upd_count = 0;
  logic sw_trig = 0, ext_trig = 0, inhibit_in = 0, upd_strobe = 0;
  logic [3:0]  flag_clr = 0;
  logic [3:0]  flags;
  logic        irq;
  logic        mem_req_valid, mem_req_ready = 1, mem_rsp_valid = 0, mem_rsp_ready;
  logic [AW-1:0] mem_req_addr;
  logic [15:0] mem_rsp_data = 0;
  logic        smp_valid, smp_ready = 1;
  logic [3:0]  smp_ch;
  logic [15:0] smp_data;

  always #5 clk = ~clk;

  wfp_playback_seq #(.IDX_W(IDX_W)) dut_i (.*);

  int n_cmp = 0, n_bad = 0, n_seen = 0, cyc = 0;
  logic [19:0] sb_q[$];

  bit m_run = 0;
  int m_pos = 0, m_rem = 0;
  logic [3:0] m_flags = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ready patterns, changed shortly after the rising edge
  initial forever begin
    @(posedge clk); #2;
    cyc++;
    smp_ready     = (cyc % 5) != 2;
    mem_req_ready = (cyc % 3) != 1;
  end

  // memory model: each word is {~addr, addr}
  initial begin
    bit taken = 0;
    forever begin
      @(negedge clk);
      if (taken) begin mem_rsp_valid = 0; taken = 0; end
      if (mem_rsp_valid && mem_rsp_ready) taken = 1;
      else if (!mem_rsp_valid && mem_req_valid && mem_req_ready) begin
        mem_rsp_valid = 1;
        mem_rsp_data  = {~mem_req_addr, mem_req_addr};
      end
    end
  end

  // monitor: scoreboard pops on each accepted sample (R2, R13)
  always @(negedge clk) begin
    if (rst_n && smp_valid && smp_ready) begin
      n_seen++;
      if (sb_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R2 unexpected sample: actual ch %0d data %0h expected none", smp_ch, smp_data);
      end else chk("R2", {12'h0, smp_ch, smp_data}, {12'h0, sb_q.pop_front()}, "sample");
    end
  end

  function automatic int last_pos(); return cfg_small ? (1 << IDX_W) - 1 : (2 << IDX_W) - 1; endfunction

  // R9 address mapping
  function automatic logic [AW-1:0] addr_of(int p, int ch);
    logic [IDX_W:0] pv = (IDX_W+1)'(p);
    if (cfg_small) return {pv[IDX_W-1], 4'(ch), 1'b0, pv[IDX_W-2:0]};
    return {pv[IDX_W], 4'(ch), pv[IDX_W-1:0]};
  endfunction

  task automatic trig(bit ext);
    @(negedge clk);
    if (ext) ext_trig = 1; else sw_trig = 1;
    @(negedge clk); ext_trig = 0; sw_trig = 0;
    if (cfg_ex && cfg_arm && !m_run) begin
      m_run = 1;
      m_rem = (upd_count == 0) ? last_pos() + 1 : int'(upd_count);
    end
  endtask

  // driver: push expected items, strobe, update model
  task automatic frame(bit extra);
    bit live = m_run && !(cfg_inh_en && inhibit_in);
    if (live) for (int c = 0; c < 16; c++) begin
      logic [AW-1:0] a = addr_of(m_pos, c);
      sb_q.push_back({4'(c), ~a, a});
    end
    @(negedge clk); upd_strobe = 1;
    @(negedge clk); upd_strobe = 0;
    if (extra) begin
      repeat (10) @(negedge clk);
      upd_strobe = 1; @(negedge clk); upd_strobe = 0;
    end
    repeat (110) @(negedge clk);
    chk("R2", sb_q.size(), 0, "frame fully delivered");
    if (live) begin
      if (m_pos == last_pos() / 2) m_flags[2] = 1;
      if (m_pos == last_pos())     m_flags[1] = 1;
      if (m_rem == 1 && cfg_cont && cfg_arm) begin
        m_rem = (upd_count == 0) ? last_pos() + 1 : int'(upd_count);
        m_pos = 0;
      end else begin
        if (m_rem == 1) begin m_run = 0; m_flags[0] = 1; end
        m_rem--;
        m_pos = (m_pos == last_pos()) ? 0 : m_pos + 1;
      end
    end
  endtask

  task automatic clear_flags(logic [3:0] v);
    @(negedge clk); flag_clr = v;
    @(negedge clk); flag_clr = 0;
    m_flags = m_flags & ~v;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk); rst_n = 1;
    m_run = 0; m_pos = 0; m_rem = 0; m_flags = 0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int seen0;
    repeat (4) @(negedge clk); rst_n = 1; @(negedge clk);
    chk("R11", flags, 0, "reset flags");
    chk("R7", irq, 0, "reset irq");
    chk("R2", {smp_valid, mem_req_valid}, 0, "reset idle streams");

    // R1: trigger without enable is ignored
    cfg_arm = 1; upd_count = 3;
    trig(0); frame(0);
    chk("R1", n_seen, 0, "no samples when disabled");

    // R1, R2, R3, R12: three updates, one extra strobe mid-frame
    cfg_ex = 1; cfg_irq_en = 3'b000;
    trig(1); frame(1); frame(0); frame(0);
    seen0 = n_seen; frame(0);
    chk("R3", n_seen - seen0, 0, "strobe after count end ignored");
    chk("R3", flags, m_flags, "done flag after count");
    chk("R7", irq, 0, "masked irq stays low");
    cfg_irq_en = 3'b001; @(negedge clk);
    chk("R7", irq, 1, "done irq enabled");

    // R11: write-1-to-clear
    clear_flags(4'b0001);
    chk("R11", flags, 0, "flag cleared");
    chk("R7", irq, 0, "irq after clear");

    // R5, R6: count crossing lower top (position 7)
    upd_count = 6; cfg_irq_en = 3'b100;
    trig(0); for (int i = 0; i < 6; i++) frame(0);
    chk("R6", flags, m_flags, "half flag");
    chk("R7", irq, 1, "half irq");

    // R4, R5, R6: whole memory from position 9, wraps past 15
    upd_count = 0; clear_flags(4'b1111);
    trig(0); for (int i = 0; i < 16; i++) frame(0);
    chk("R4", flags, 4'b0111, "whole memory flags");
    chk("R5", m_pos, 9, "model position after full wrap");

    // R8: repeat mode, count 2, no done flag
    clear_flags(4'b1111); cfg_cont = 1; upd_count = 2;
    trig(0); for (int i = 0; i < 5; i++) frame(0);
    chk("R8", flags[0], 0, "no done in repeat mode");
    chk("R8", flags, m_flags, "repeat flags");
    cfg_cont = 0;
    while (m_run) frame(0);
    chk("R8", flags[0], 1, "done after repeat released");

    // R9, R10: reduced depth, inhibit in the middle
    do_reset(); cfg_small = 1; upd_count = 0;
    trig(0); frame(0); frame(0);
    cfg_inh_en = 1; inhibit_in = 1; m_flags[3] = 1;
    seen0 = n_seen; frame(0);
    chk("R10", n_seen - seen0, 0, "strobe ignored under inhibit");
    chk("R10", flags[3], 1, "inhibit flag");
    inhibit_in = 0;
    while (m_run) frame(0);
    chk("R9", flags, m_flags, "reduced depth flags");
    chk("R9", m_pos, 0, "reduced depth wrap");

    finish_run();
  end
endmodule